// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives words over a half-duplex synchronous serial link on which it is the clock master. When receive is enabled it produces the shift clock on `sck`. It captures the serial data input `dt_in` on each falling edge of that clock, least significant bit first. Each word is 8 bits, or 9 bits when the ninth-bit mode is selected. A finished word is moved into a holding register, and a receive-complete flag is raised. That flag can also drive an interrupt output.

Software controls the block through a 7-bit control register and an 8-bit divisor register. Receive can run in one of two modes. In single-word mode one word is received, then the enable bit clears itself. In continuous mode words are received back to back for as long as the enable stays set. If both enables are set, continuous mode wins. Reading the data clears the flag. If a word completes while the previous word is still unread, the new word is discarded and an overrun status is set. Writing the control register with the continuous enable at 0 clears that status.

Top module: `sync_master_rx`

## Requirements
- R1: After reset, the control register, the divisor, the data output, the ninth bit, the flag, the overrun status, the interrupt and `sck` are all 0.
- R2: Control register bit positions are: 0 port enable, 1 synchronous mode, 2 clock master, 3 single-word enable, 4 continuous enable, 5 nine-bit mode, 6 interrupt enable. Bit 7 of the write data is ignored. The shift clock runs only while bits 0, 1 and 2 are all 1 and at least one of bits 3 and 4 is 1. Otherwise `sck` stays low.
- R3: With divisor value D, the shift clock has a period of 4*(D+1) system clocks, high for half of it and low for the other half. It starts with a low half that begins on the clock edge that first sees the enable.
- R4: `dt_in` is captured on each falling edge of `sck`. The first captured bit becomes data bit 0 and later bits fill upward, least significant bit first.
- R5: In single-word mode exactly one word is received. Bit 3 of the control register then reads 0 and the clock returns to low.
- R6: In continuous mode words follow each other with no gap. Clearing bit 4 in the middle of a word stops the clock and abandons the partial word. The next enable starts again at bit 0.
- R7: When bits 3 and 4 are both set, reception goes on after the first word, even though bit 3 self-clears.
- R8: In nine-bit mode each word has 9 bits, and the ninth captured bit appears on `rx_bit9`. In eight-bit mode `rx_bit9` is 0.
- R9: The flag `rx_flag` rises in the cycle after the word's final falling edge. `rx_irq` equals the flag ANDed with bit 6.
- R10: A pulse on `rd_stb` clears the flag. If a read and a word completion fall in the same cycle, the new word is accepted, the flag stays 1 and no overrun is recorded.
- R11: If a word completes while the flag is 1 and no read arrives in that cycle, `rx_ovr` becomes 1 and the data output keeps the older word.
- R12: A control write with bit 4 at 0 clears `rx_ovr`. A control write with bit 4 at 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | DIV_W | Divisor write data |
| rd_stb | input | 1 | Data register read pulse |
| dt_in | input | 1 | Serial data from the link |
| sck | output | 1 | Generated shift clock |
| ctl_rdata | output | 8 | Control register readback |
| rx_data | output | DATA_W | Received word |
| rx_bit9 | output | 1 | Ninth received bit |
| rx_flag | output | 1 | Receive-complete flag |
| rx_ovr | output | 1 | Overrun status |
| rx_irq | output | 1 | Receive interrupt |

## Verification
A data read and a word completion can happen in the same cycle. The same is true of a control write and a word completion, and of a control write and an overrun. The bench model predicts the exact edge of each final falling edge. It places a read pulse on that cycle, so that the flag must stay set with the new word and no overrun. Control writes that set or clear the continuous enable are issued while an overrun is pending, and the per-cycle comparison judges the outcome.

// File: rtl/smrx_pkg.sv
package smrx_pkg;

  // Control register layout, LSB first: port_en is bit 0.
  typedef struct packed {
    logic int_en;
    logic nine;
    logic cont;
    logic single;
    logic master;
    logic sync;
    logic port_en;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);

  // System clocks per half shift-clock period.
  function automatic int unsigned half_len(int unsigned div);
    return 2 * (div + 1);
  endfunction

  // Number of bits per word.
  function automatic int unsigned word_len(logic nine, int unsigned data_w);
    return nine ? data_w + 1 : data_w;
  endfunction

  // Receive runs only in synchronous master mode with an enable set.
  function automatic logic rx_active(ctl_t c);
    return c.port_en & c.sync & c.master & (c.single | c.cont);
  endfunction

endpackage

// File: rtl/smrx_clkgen.sv
module smrx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             running,
  output logic             fall_evt
);
  import smrx_pkg::*;

  localparam int HALF_W = DIV_W + 2;

  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] last_cnt;
  logic              at_end;

  assign last_cnt = HALF_W'(half_len(32'(div)) - 1);
  assign at_end   = running && (cnt >= last_cnt);
  assign fall_evt = run_en && at_end && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      sck     <= 1'b0;
      cnt     <= '0;
    end else if (!run_en) begin
      running <= 1'b0;
      sck     <= 1'b0;
      cnt     <= '0;
    end else if (!running) begin
      running <= 1'b1;
      sck     <= 1'b0;
      cnt     <= '0;
    end else if (at_end) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !sck);

  // R3
  sck_low_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !$past(running)) |-> !sck);

  // R4
  fall_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !sck);

endmodule

// File: rtl/smrx_shifter.sv
module smrx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic            sample,
  input  logic            nine,
  input  logic            dt_in,
  output logic            word_done,
  output logic [DATA_W:0] word
);
  import smrx_pkg::*;

  localparam int W     = DATA_W + 1;
  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     shreg;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] last_idx;

  assign last_idx  = CNT_W'(word_len(nine, DATA_W) - 1);
  assign word_done = sample && (idx >= last_idx);

  // Bypass the bit being captured this cycle so the word is whole at done.
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign word[g] = (sample && idx == CNT_W'(g)) ? dt_in : shreg[g];
  end
  assign word[DATA_W] = nine &&
    ((sample && idx == CNT_W'(DATA_W)) ? dt_in : shreg[DATA_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      shreg <= '0;
    end else if (!run_en) begin
      idx <= '0;
    end else if (sample) begin
      for (int i = 0; i < W; i++) begin
        if (idx == CNT_W'(i)) shreg[i] <= dt_in;
      end
      idx <= word_done ? '0 : idx + 1'b1;
    end
  end

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && run_en) |=> (idx == '0 || idx == $past(idx) + 1'b1));

  // R6
  idx_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> idx == '0);

endmodule

// File: rtl/smrx_holding.sv
module smrx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic [DATA_W:0]   word,
  input  logic              rd_stb,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_flag,
  output logic              rx_ovr
);
  logic accept;
  logic reject;

  assign accept = word_done && (!rx_flag || rd_stb);
  assign reject = word_done && rx_flag && !rd_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_bit9 <= 1'b0;
      rx_flag <= 1'b0;
      rx_ovr  <= 1'b0;
    end else begin
      if (accept) begin
        rx_data <= word[DATA_W-1:0];
        rx_bit9 <= word[DATA_W];
      end
      if (accept)      rx_flag <= 1'b1;
      else if (rd_stb) rx_flag <= 1'b0;
      if (ovr_clr)     rx_ovr <= 1'b0;
      else if (reject) rx_ovr <= 1'b1;
    end
  end

  // R9
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> $past(word_done));

  // R10
  read_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rd_stb) |=> rx_flag);

  // R11
  ovr_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_flag));

  // R11
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rx_flag && !rd_stb) |=> $stable(rx_data));

endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  input  logic              div_wr,
  input  logic [DIV_W-1:0]  div_wdata,
  input  logic              rd_stb,
  input  logic              dt_in,
  output logic              sck,
  output logic [7:0]        ctl_rdata,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_flag,
  output logic              rx_ovr,
  output logic              rx_irq
);
  import smrx_pkg::*;

  ctl_t             ctl_q;
  ctl_t             wr_ctl;
  logic [DIV_W-1:0] div_q;
  logic             run_en;
  logic             running;
  logic             fall_evt;
  logic             word_done;
  logic [DATA_W:0]  word;
  logic             ovr_clr;

  assign wr_ctl    = ctl_t'(ctl_wdata[CTL_W-1:0]);
  assign run_en    = rx_active(ctl_q);
  assign ovr_clr   = ctl_wr && !wr_ctl.cont;
  assign rx_irq    = rx_flag && ctl_q.int_en;
  assign ctl_rdata = {{(8 - CTL_W){1'b0}}, ctl_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      div_q <= '0;
    end else begin
      if (ctl_wr)         ctl_q <= wr_ctl;
      else if (word_done) ctl_q.single <= 1'b0;
      if (div_wr)         div_q <= div_wdata;
    end
  end

  smrx_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .div      (div_q),
    .sck      (sck),
    .running  (running),
    .fall_evt (fall_evt)
  );

  smrx_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .sample    (fall_evt),
    .nine      (ctl_q.nine),
    .dt_in     (dt_in),
    .word_done (word_done),
    .word      (word)
  );

  smrx_holding #(.DATA_W(DATA_W)) i_holding (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_done (word_done),
    .word      (word),
    .rd_stb    (rd_stb),
    .ovr_clr   (ovr_clr),
    .rx_data   (rx_data),
    .rx_bit9   (rx_bit9),
    .rx_flag   (rx_flag),
    .rx_ovr    (rx_ovr)
  );

  // R5
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !ctl_wr) |=> !ctl_q.single);

  // R2
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> $past(run_en));

  // R9
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_flag);

endmodule

// File: tb/test_sync_master_rx.sv
module test_sync_master_rx;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr;
  logic [7:0] ctl_wdata;
  logic       div_wr;
  logic [7:0] div_wdata;
  logic       rd_stb;
  logic       dt_in = 1'b0;
  logic       sck;
  logic [7:0] ctl_rdata;
  logic [7:0] rx_data;
  logic       rx_bit9;
  logic       rx_flag;
  logic       rx_ovr;
  logic       rx_irq;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit started = 0;

  always #10 clk = ~clk;  // 50 MHz

  sync_master_rx i_sync_master_rx (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .div_wr(div_wr), .div_wdata(div_wdata), .rd_stb(rd_stb), .dt_in(dt_in),
    .sck(sck), .ctl_rdata(ctl_rdata), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .rx_flag(rx_flag), .rx_ovr(rx_ovr), .rx_irq(rx_irq)
  );

  // Reference model state
  logic [6:0] m_ctl;
  int         m_div, m_k, m_bit, m_h, m_n;
  logic [8:0] m_shift, pat = 9'h1A5, last_pat;
  logic [7:0] m_data;
  logic       m_b9, m_flag, m_ovr, m_sck, m_act, m_done, old_flag;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit model_active();
    return m_ctl[0] && m_ctl[1] && m_ctl[2] && (m_ctl[3] || m_ctl[4]);
  endfunction

  function automatic bit next_is_done();
    int h = 2 * (m_div + 1);
    int n = m_ctl[5] ? 9 : 8;
    return model_active() && m_k >= 0 && ((m_k + 1) % (2 * h) == 0)
           && m_bit == n - 1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (!rst_n) begin
      m_ctl = '0; m_div = 0; m_k = -1; m_bit = 0; m_shift = '0;
      m_data = '0; m_b9 = 0; m_flag = 0; m_ovr = 0; m_sck = 0;
    end else begin
      m_act  = model_active();
      m_h    = 2 * (m_div + 1);
      m_n    = m_ctl[5] ? 9 : 8;
      m_done = 0;
      if (!m_act) begin
        m_k = -1; m_sck = 0; m_bit = 0;
      end else if (m_k < 0) begin
        m_k = 0; m_sck = 0; m_bit = 0;
      end else begin
        m_k++;
        if (m_k % m_h == 0) begin
          m_sck = !m_sck;
          if (m_k % (2 * m_h) == 0) begin
            m_shift[m_bit] = dt_in;
            if (m_bit == m_n - 1) begin m_done = 1; m_bit = 0; end
            else m_bit++;
          end
        end
      end
      old_flag = m_flag;
      if (rd_stb) m_flag = 0;
      if (m_done) begin
        if (old_flag && !rd_stb) m_ovr = 1;
        else begin
          m_data = m_shift[7:0];
          m_b9   = (m_n == 9) ? m_shift[8] : 1'b0;
          m_flag = 1;
        end
        m_ctl[3] = 0;
        last_pat = pat;
        pat      = pat * 9'd7 + 9'd93;
      end
      if (ctl_wr) begin
        m_ctl = ctl_wdata[6:0];
        if (!ctl_wdata[4]) m_ovr = 0;
      end
      if (div_wr) m_div = int'(div_wdata);
    end
  end

  // Per-cycle comparison and data-line drive, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk(sck == m_sck, "R3", "sck", sck, m_sck);
      chk(rx_flag == m_flag, "R9", "rx_flag", rx_flag, m_flag);
      chk(rx_irq == (m_flag && m_ctl[6]), "R9", "rx_irq", rx_irq, m_flag && m_ctl[6]);
      chk(rx_ovr == m_ovr, "R11", "rx_ovr", rx_ovr, m_ovr);
      chk(rx_data == m_data, "R4", "rx_data", rx_data, m_data);
      chk(rx_bit9 == m_b9, "R8", "rx_bit9", rx_bit9, m_b9);
      chk(ctl_rdata == {1'b0, m_ctl}, "R5", "ctl_rdata", ctl_rdata, {1'b0, m_ctl});
    end
    dt_in = pat[m_bit];
  end

  task automatic write_ctl(input logic [7:0] v);
    ctl_wr = 1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic set_div(input logic [7:0] v);
    div_wr = 1; div_wdata = v;
    @(negedge clk);
    div_wr = 0;
  endtask

  task automatic do_read();
    rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
  endtask

  task automatic wait_flag();
    while (!rx_flag) @(negedge clk);
  endtask

  task automatic count_rises(input int n, output int rises);
    logic prv = sck;
    rises = 0;
    repeat (n) begin
      @(negedge clk);
      if (!prv && sck) rises++;
      prv = sck;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  int rises, t_r1, t_f, t_r2;
  logic prv;
  logic [7:0] keep;

  initial begin
    rst_n = 0; ctl_wr = 0; ctl_wdata = 0; div_wr = 0; div_wdata = 0; rd_stb = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sck == 0, "R1", "sck", sck, 0);
    chk(rx_flag == 0 && rx_ovr == 0 && rx_irq == 0, "R1", "status", {rx_flag, rx_ovr, rx_irq}, 0);
    chk(rx_data == 0 && rx_bit9 == 0, "R1", "data", rx_data, 0);
    chk(ctl_rdata == 0, "R1", "ctl", ctl_rdata, 0);
    rst_n = 1;
    @(negedge clk);

    // R5 single 8-bit word, fastest clock
    set_div(8'd0);
    write_ctl(8'h0F);
    wait_flag();
    chk(rx_data == last_pat[7:0], "R4", "single word", rx_data, last_pat[7:0]);
    chk(ctl_rdata[3] == 0, "R5", "single self-clear", ctl_rdata[3], 0);
    count_rises(20, rises);
    chk(rises == 0 && sck == 0, "R5", "clock stopped", rises, 0);
    do_read();
    chk(rx_flag == 0, "R10", "read clears flag", rx_flag, 0);

    // R8 nine-bit word
    set_div(8'd2);
    write_ctl(8'h2F);
    wait_flag();
    chk(rx_data == last_pat[7:0], "R8", "nine-bit data", rx_data, last_pat[7:0]);
    chk(rx_bit9 == last_pat[8], "R8", "ninth bit", rx_bit9, last_pat[8]);
    do_read();

    // R2 gating: missing sync, missing master, missing port enable
    write_ctl(8'h1D);
    count_rises(60, rises);
    chk(rises == 0, "R2", "no sync", rises, 0);
    write_ctl(8'h1B);
    count_rises(60, rises);
    chk(rises == 0, "R2", "no master", rises, 0);
    write_ctl(8'h1E);
    count_rises(60, rises);
    chk(rises == 0, "R2", "no port enable", rises, 0);
    write_ctl(8'h00);

    // R3 period and duty with D=3
    set_div(8'd3);
    write_ctl(8'h17);
    prv = sck; t_r1 = -1; t_f = -1; t_r2 = -1;
    while (t_r2 < 0) begin
      @(negedge clk);
      if (!prv && sck) begin
        if (t_r1 < 0) t_r1 = cyc; else t_r2 = cyc;
      end
      if (prv && !sck && t_r1 >= 0) t_f = cyc;
      prv = sck;
    end
    chk(t_r2 - t_r1 == 16, "R3", "period", t_r2 - t_r1, 16);
    chk(t_f - t_r1 == 8, "R3", "high time", t_f - t_r1, 8);
    write_ctl(8'h00);
    repeat (4) @(negedge clk);

    // R6 continuous with interrupt enabled
    set_div(8'd1);
    write_ctl(8'h57);
    for (int w = 0; w < 3; w++) begin
      wait_flag();
      chk(rx_irq == 1, "R9", "irq", rx_irq, 1);
      chk(rx_data == last_pat[7:0], "R6", "continuous word", rx_data, last_pat[7:0]);
      do_read();
    end

    // R10 read coinciding with completion
    wait_flag();
    while (!next_is_done()) @(negedge clk);
    do_read();
    chk(rx_flag == 1, "R10", "flag after collision", rx_flag, 1);
    chk(rx_ovr == 0, "R10", "no overrun on collision", rx_ovr, 0);
    chk(rx_data == last_pat[7:0], "R10", "new word taken", rx_data, last_pat[7:0]);
    keep = rx_data;

    // R11 overrun keeps older word
    while (!rx_ovr) @(negedge clk);
    chk(rx_data == keep, "R11", "data kept", rx_data, keep);
    write_ctl(8'h57);
    chk(rx_ovr == 1, "R12", "cont=1 write keeps overrun", rx_ovr, 1);
    write_ctl(8'h47);
    chk(rx_ovr == 0, "R12", "cont=0 write clears overrun", rx_ovr, 0);
    count_rises(30, rises);
    chk(rises == 0, "R6", "stopped after clear", rises, 0);
    do_read();

    // R6 abort mid-word and restart from bit 0
    write_ctl(8'h17);
    while (m_bit != 4) @(negedge clk);
    write_ctl(8'h07);
    count_rises(20, rises);
    chk(rx_flag == 0 && rises == 0, "R6", "partial word dropped", rx_flag, 0);
    write_ctl(8'h17);
    wait_flag();
    chk(rx_data == last_pat[7:0], "R6", "restart word", rx_data, last_pat[7:0]);
    write_ctl(8'h00);
    do_read();

    // R7 both enables: continuous wins
    write_ctl(8'h1F);
    wait_flag();
    chk(ctl_rdata[3] == 0, "R7", "single bit cleared", ctl_rdata[3], 0);
    do_read();
    wait_flag();
    chk(rx_data == last_pat[7:0], "R7", "second word received", rx_data, last_pat[7:0]);
    write_ctl(8'h00);
    do_read();
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule